// File: doc/BRIEF.md
# Single-Word Parallel Bus Initiator

This block is the initiator side of a shared, synchronous parallel bus whose control lines are active low and whose 32-bit address/data lines are multiplexed. A local requester places an address, a command code, byte enables and (for writes) a data word on a request port. The engine then runs one complete single-word bus transaction. It drives an address phase, then a single data phase, and waits for a target to claim the cycle and signal ready. It ends the transaction by releasing the bus and returns a one-clock acknowledge with a status bit and the captured read data.

The bidirectional address/data and command/byte-enable lines are modelled as separate input, output and output-enable signals, so the block can sit behind pad logic. When no target claims the cycle within a fixed window, the engine gives up and reports a master abort through the same acknowledge. Bursts, arbitration, parity and wide transfers are not handled.

Top module: `pbus_initiator`

## Requirements
- R1: While rst_ni is low and after reset, frame_no and irdy_no are high, ad_oe_o, cbe_oe_o and ack_o are low.
- R2: When req_i is high in an idle clock, the following clock is the address phase: frame_no low, irdy_no high, ad_o equals req_addr_i, cbe_no equals req_cmd_i unchanged (4'b0110 memory read, 4'b0111 memory write), both output enables high.
- R3: The clock after the address phase begins the only data phase: frame_no high and irdy_no low together, and cbe_no carries the inverted byte enables (req_be_i bit n high selects byte n, so cbe_no = ~req_be_i).
- R4: Bit 0 of the command selects a write when 1; in a write data phase ad_oe_o is high and ad_o carries req_wdata_i.
- R5: In a read data phase ad_oe_o is low from the first data-phase clock on, leaving one turnaround clock for the target.
- R6: At the first clock edge in the data phase where devsel_ni and trdy_ni are both low, the word moves: in the next clock irdy_no and frame_no are high, both output enables are low, ack_o is high for exactly one clock with abort_o low, and for a read rdata_o holds the ad_i value from that edge.
- R7: If devsel_ni is not sampled low on any of the first ABORT_CLKS data-phase edges (default 6), the cycle is ended after that edge with the bus released and ack_o high with abort_o high; a claim on the last of those edges is a normal claim.
- R8: trdy_ni low while devsel_ni is high does not complete the transfer; irdy_no stays low.
- R9: Request inputs that change during a transaction have no effect on the bus values of that transaction, and no new address phase starts in the clock where ack_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a transaction; held until ack_o |
| req_addr_i | input | 32 | Transaction address |
| req_cmd_i | input | 4 | Command code, bit 0 high means write |
| req_be_i | input | 4 | Byte enables, active high |
| req_wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-clock completion pulse |
| abort_o | output | 1 | With ack_o: cycle ended by master abort |
| rdata_o | output | 32 | Read data captured on the transfer edge |
| frame_no | output | 1 | Cycle framing, active low |
| irdy_no | output | 1 | Initiator ready, active low |
| devsel_ni | input | 1 | Target claim, active low |
| trdy_ni | input | 1 | Target ready, active low |
| ad_i | input | 32 | Address/data lines as seen from the bus |
| ad_o | output | 32 | Address/data value driven by the initiator |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| cbe_no | output | 4 | Command / byte-enable lines, driven value |
| cbe_oe_o | output | 1 | Drive enable for cbe_no |

## Verification
The bench builds the block with its defaults: a 32-bit bus and a six-clock claim window. The short window lets random claim delays from zero to seven clocks fall on both sides of the abort boundary, so normal claims, a claim on the sixth edge and master aborts all occur. Ready delays are drawn independently of the claim delay, which also produces cases where the target signals ready before it claims the cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } pbus_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pbus_claim_timer.sv
module pbus_claim_timer #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic claim_i,
  output logic abort_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          claimed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      claimed_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q     <= '0;
      claimed_q <= 1'b0;
    end else begin
      if (claim_i) claimed_q <= 1'b1;
      if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign abort_o = run_i && !claimed_q && !claim_i && (cnt_q == CW'(LIMIT - 1));

  // window can only expire after the data phase has run for a while
  assert_abort_after_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(run_i));
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [3:0]    req_cmd_i,
  input  logic [BW-1:0] req_be_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          xfer_i,
  input  logic          abort_i,
  input  logic [DW-1:0] ad_i,
  output pbus_state_e   state_o,
  output logic [AW-1:0] addr_o,
  output logic [3:0]    cmd_o,
  output logic [BW-1:0] be_o,
  output logic [DW-1:0] wdata_o,
  output logic          write_o,
  output logic          ack_o,
  output logic          abort_o,
  output logic [DW-1:0] rdata_o
);
  pbus_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_o  <= '0;
      cmd_o   <= '0;
      be_o    <= '0;
      wdata_o <= '0;
      ack_o   <= 1'b0;
      abort_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i && !ack_o) begin
            state_q <= ST_ADDR;
            addr_o  <= req_addr_i;
            cmd_o   <= req_cmd_i;
            be_o    <= req_be_i;
            wdata_o <= req_wdata_i;
          end
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          if (xfer_i) begin
            state_q <= ST_IDLE;
            ack_o   <= 1'b1;
            abort_o <= 1'b0;
            if (!cmd_o[0]) rdata_o <= ad_i;
          end else if (abort_i) begin
            state_q <= ST_IDLE;
            ack_o   <= 1'b1;
            abort_o <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign write_o = cmd_o[0];

  assert_no_double_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_i && abort_i));
  assert_ack_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/pbus_drive.sv
module pbus_drive
  import pbus_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned BW = DW / 8
) (
  input  pbus_state_e   state_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    cmd_i,
  input  logic [BW-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          write_i,
  output logic          frame_no,
  output logic          irdy_no,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [BW-1:0] cbe_no,
  output logic          cbe_oe_o
);
  always_comb begin
    frame_no = 1'b1;
    irdy_no  = 1'b1;
    ad_o     = '0;
    ad_oe_o  = 1'b0;
    cbe_no   = '1;
    cbe_oe_o = 1'b0;
    unique case (state_i)
      ST_ADDR: begin
        frame_no = 1'b0;
        ad_o     = DW'(addr_i);
        ad_oe_o  = 1'b1;
        cbe_no   = BW'(cmd_i);
        cbe_oe_o = 1'b1;
      end
      ST_DATA: begin
        // single word: frame released together with irdy asserted
        irdy_no  = 1'b0;
        cbe_no   = ~be_i;
        cbe_oe_o = 1'b1;
        ad_oe_o  = write_i;
        ad_o     = write_i ? wdata_i : '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pbus_initiator.sv
module pbus_initiator
  import pbus_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ABORT_CLKS = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [3:0]    req_cmd_i,
  input  logic [3:0]    req_be_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          ack_o,
  output logic          abort_o,
  output logic [DW-1:0] rdata_o,
  output logic          frame_no,
  output logic          irdy_no,
  input  logic          devsel_ni,
  input  logic          trdy_ni,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [3:0]    cbe_no,
  output logic          cbe_oe_o
);
  localparam int unsigned BW = 4;

  pbus_state_e   state;
  logic [DW-1:0] addr_q, wdata_q;
  logic [3:0]    cmd_q;
  logic [BW-1:0] be_q;
  logic          write_q, in_data, xfer, tmo;

  assign in_data = (state == ST_DATA);
  assign xfer    = in_data && !devsel_ni && !trdy_ni;

  pbus_claim_timer #(.LIMIT(ABORT_CLKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (in_data),
    .claim_i (!devsel_ni),
    .abort_o (tmo)
  );

  pbus_seq #(.AW(DW), .DW(DW), .BW(BW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_addr_i  (req_addr_i),
    .req_cmd_i   (req_cmd_i),
    .req_be_i    (req_be_i),
    .req_wdata_i (req_wdata_i),
    .xfer_i      (xfer),
    .abort_i     (tmo),
    .ad_i        (ad_i),
    .state_o     (state),
    .addr_o      (addr_q),
    .cmd_o       (cmd_q),
    .be_o        (be_q),
    .wdata_o     (wdata_q),
    .write_o     (write_q),
    .ack_o       (ack_o),
    .abort_o     (abort_o),
    .rdata_o     (rdata_o)
  );

  pbus_drive #(.AW(DW), .DW(DW), .BW(BW)) u_drive (
    .state_i  (state),
    .addr_i   (addr_q),
    .cmd_i    (cmd_q),
    .be_i     (be_q),
    .wdata_i  (wdata_q),
    .write_i  (write_q),
    .frame_no (frame_no),
    .irdy_no  (irdy_no),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .cbe_no   (cbe_no),
    .cbe_oe_o (cbe_oe_o)
  );

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_no && irdy_no) |-> (!ad_oe_o && !cbe_oe_o));
  assert_addr_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_no |-> (irdy_no && ad_oe_o && cbe_oe_o));
  assert_last_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_no |=> (frame_no && !irdy_no));
  assert_read_turn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && !write_q) |-> !ad_oe_o);
  assert_complete_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && !devsel_ni && !trdy_ni) |=> (ack_o && !abort_o && irdy_no));
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (frame_no && irdy_no && !ad_oe_o && !cbe_oe_o));
  assert_abort_claimless_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && abort_o) |-> $past(devsel_ni));
  assert_trdy_alone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && devsel_ni && !trdy_ni && !tmo) |=> !irdy_no);
  assert_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> frame_no);
endmodule

// File: tb/sim_pbus_initiator.sv
module sim_pbus_initiator;
  localparam int DW = 32;
  localparam int LIM = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [DW-1:0] req_addr = '0, req_wdata = '0, ad_in = '0;
  logic [3:0]    req_cmd = '0, req_be = '0;
  logic          devsel_n = 1'b1, trdy_n = 1'b1;
  logic          ack, abrt, frame_n, irdy_n, ad_oe, cbe_oe;
  logic [DW-1:0] rdata, ad_out;
  logic [3:0]    cbe_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pbus_initiator #(.DW(DW), .ABORT_CLKS(LIM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .req_cmd_i(req_cmd), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .ack_o(ack), .abort_o(abrt), .rdata_o(rdata), .frame_no(frame_n),
    .irdy_no(irdy_n), .devsel_ni(devsel_n), .trdy_ni(trdy_n), .ad_i(ad_in),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .cbe_no(cbe_n), .cbe_oe_o(cbe_oe)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit exp_abort(input int dev_dly);
    return dev_dly >= LIM;
  endfunction

  function automatic int exp_end_edge(input int dev_dly, input int rdy_dly);
    if (exp_abort(dev_dly)) return LIM;
    return (dev_dly > rdy_dly ? dev_dly : rdy_dly) + 1;
  endfunction

  // dev_dly / rdy_dly: number of data-phase edges before devsel/trdy go low
  task automatic txn(input logic [3:0] cmd, input logic [31:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic [31:0] rd,
                     input int dev_dly, input int rdy_dly);
    bit wr = cmd[0];
    int last = exp_end_edge(dev_dly, rdy_dly);
    @(negedge clk);
    req = 1'b1; req_cmd = cmd; req_addr = a; req_be = be; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    chk(!frame_n && irdy_n && ad_oe && cbe_oe, "R2 addr phase ctl", {frame_n, irdy_n, ad_oe, cbe_oe}, 4'b0111);
    chk(ad_out == a, "R2 address", ad_out, a);
    chk(cbe_n == cmd, "R2 command", cbe_n, cmd);
    req_addr = ~a; req_wdata = ~wd; req_be = ~be; req_cmd = ~cmd;  // R9 changes while busy
    @(posedge clk); @(negedge clk);
    chk(frame_n && !irdy_n, "R3 frame/irdy", {frame_n, irdy_n}, 2'b10);
    chk(cbe_n == ~be, "R3 byte enables", cbe_n, ~be);
    if (wr) chk(ad_oe && ad_out == wd, "R4 write drive R9", {ad_oe, ad_out}, {1'b1, wd});
    else    chk(!ad_oe, "R5 read turnaround", ad_oe, 0);
    for (int k = 1; k <= 20; k++) begin
      devsel_n = !(k > dev_dly);
      trdy_n   = !(k > rdy_dly);
      ad_in    = (!trdy_n && !wr) ? rd : 32'hDEAD_BEEF;
      @(posedge clk); @(negedge clk);
      devsel_n = 1'b1; trdy_n = 1'b1;
      if (k == last) begin
        if (exp_abort(dev_dly)) chk(ack && abrt, "R7 master abort", {ack, abrt}, 2'b11);
        else                    chk(ack && !abrt, "R6 completion", {ack, abrt}, 2'b10);
        chk(frame_n && irdy_n && !ad_oe && !cbe_oe, "R6 bus released", {frame_n, irdy_n, ad_oe, cbe_oe}, 4'b1100);
        if (!wr && !exp_abort(dev_dly)) chk(rdata == rd, "R6 read data", rdata, rd);
        req = 1'b0;
        break;
      end else begin
        chk(!ack && !irdy_n, (!devsel_n || dev_dly >= k) ? "R8 still waiting" : "R6 waiting",
            {ack, irdy_n}, 2'b00);
      end
    end
    @(posedge clk); @(negedge clk);
    chk(!ack && frame_n, "R9 gap after ack", {ack, frame_n}, 2'b01);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(frame_n && irdy_n && !ad_oe && !cbe_oe && !ack, "R1 in reset",
        {frame_n, irdy_n, ad_oe, cbe_oe, ack}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_n && irdy_n && !ad_oe && !cbe_oe && !ack, "R1 after reset",
        {frame_n, irdy_n, ad_oe, cbe_oe, ack}, 5'b11000);
    // directed corners
    txn(pbus_pkg::CMD_MEM_RD, 32'h1000_0004, 4'hF, 32'h0, 32'hCAFE_0001, 0, 0);
    txn(pbus_pkg::CMD_MEM_WR, 32'h2000_0008, 4'h3, 32'h1234_5678, 32'h0, 1, 3);
    txn(pbus_pkg::CMD_MEM_RD, 32'h3000_0000, 4'h1, 32'h0, 32'hA5A5_5A5A, LIM - 1, 2);   // R7 claim on last edge
    txn(pbus_pkg::CMD_MEM_RD, 32'h4000_0000, 4'hF, 32'h0, 32'h1111_2222, LIM, 0);       // R7 abort
    txn(pbus_pkg::CMD_MEM_WR, 32'h5000_0000, 4'hC, 32'h9999_0000, 32'h0, 4, 0);         // R8 trdy first
    for (int i = 0; i < 60; i++) begin
      logic [3:0] c = ($urandom_range(0, 1) != 0) ? pbus_pkg::CMD_MEM_WR : pbus_pkg::CMD_MEM_RD;
      txn(c, $urandom(), 4'($urandom_range(0, 15)), $urandom(), $urandom(),
          $urandom_range(0, LIM + 1), $urandom_range(0, 8));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule